// File: doc/BRIEF.md
# UART with Multiprocessor Address Filtering

This block is a full-duplex asynchronous serial port. A shared baud generator produces a tick at 16 times the bit rate. The period of that tick comes from a 12-bit divisor, which arrives as a 4-bit high part and an 8-bit low part.

The transmit side has one holding register in front of a frame shifter. The receive side oversamples its line and decides every bit by a vote of three samples. It delivers complete characters through one output register. Characters carry 8 or 9 data bits. A multiprocessor filter can drop every character that is not marked as an address.

Words enter and leave as valid/ready streams.

- **Transmit stream.** `tx_ready` is high exactly when the holding register is empty. A word is accepted on any clock edge where `tx_valid` and `tx_ready` are both high.
- **Receive stream.** `rx_valid` stays high and `rx_data` stays stable until the consumer raises `rx_ready`. The serial line cannot be stalled. Back-pressure is therefore lossy: a character that completes while the previous one is still unread is dropped, and `rx_overrun` reports the loss.

Top module: `uart_mp`

## Requirements
- R1: The divisor is `{div_hi, div_lo}`. One oversampling tick occurs every divisor+1 clocks, and every transmitted bit lasts exactly 16*(divisor+1) clocks.
- R2: A transmitted frame has the following layout, and `txd` is high whenever no frame is being sent:
  - a low start bit;
  - the data bits, least significant first: 8 of them, or 9 when `nine_bit` is 1, in which case `tx_data[8]` is the ninth;
  - one high stop bit.
- R3: `tx_ready` is low while a word waits in the holding register. A held word is moved into the shifter at the tick that ends the stop bit of the frame in progress, which frees the holding register.
- R4: `tx_done` is 0 after reset. It rises when a stop bit finishes with no word waiting, and it returns to 0 when a new word is accepted.
- R5: When the line is idle, a single low sample starts start-bit detection. If the majority of samples 8, 9 and 10 of that bit is high, the receiver returns to idle, so a low pulse of only a few samples produces no character.
- R6: Each received bit takes the majority value of its samples 8, 9 and 10. A single inverted sample therefore does not change the decoded bit.
- R7: A received character is presented on `rx_data` with `rx_valid` high until it is taken with `rx_ready`. `rx_data[8]` carries the ninth bit in 9-bit mode and is 0 in 8-bit mode.
- R8: `rx_frame_err` is 1 together with a character whose stop bit was decided low, and it is 0 for a character with a high stop bit.
- R9: Overrun works as follows:
  - A character that completes while `rx_valid` is high and no pop happens in that cycle is discarded.
  - The older character stays on `rx_data`, and `rx_overrun` rises alongside it until that character is popped.
  - Without a loss, `rx_overrun` stays 0.
- R10: With `mp_mode` at 1, a character whose flag bit is 0 is discarded with no effect on `rx_valid`, `rx_frame_err` or `rx_overrun`. The flag bit is the ninth data bit in 9-bit mode and the bit in the stop position in 8-bit mode. Lowering `mp_mode` restores normal reception.
- R11: After reset, `txd` = 1, `tx_ready` = 1, `tx_done` = 0, `rx_valid` = 0, `rx_frame_err` = 0 and `rx_overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi | input | 4 | Upper part of the baud divisor |
| div_lo | input | 8 | Lower part of the baud divisor |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| mp_mode | input | 1 | Drop characters whose flag bit is 0 |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty, word accepted |
| tx_data | input | 9 | Transmit word; bit 8 is used in 9-bit mode |
| txd | output | 1 | Serial transmit line |
| tx_done | output | 1 | Transmission complete, nothing pending |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Consumer takes the character |
| rx_data | output | 9 | Received character |
| rx_frame_err | output | 1 | Stop bit of the presented character was low |
| rx_overrun | output | 1 | A later character was lost behind this one |

## Verification
The bench builds the block with its default parameters: a 4+8-bit divisor and a two-stage input synchronizer.

With the divisor at 0, each bit lasts 16 clocks. At that rate the bench can loop the transmitter into the receiver for every 8-bit value and a broad spread of 9-bit values. It also drives hand-built frames directly into the receiver, which lets it check frames with:
- a zero stop bit;
- a short start pulse;
- single-sample glitches;
- address and data flags.

Divisors of 2, 5 and 256 (the last with a nonzero high part) are used to check bit timing and the position of each bit on `txd`.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  localparam int OVS      = 16;
  localparam int OVS_W    = $clog2(OVS);
  localparam int WORD_W   = 9;
  localparam int FRAME_W  = WORD_W + 2;
  localparam int BIT_W    = 4;

  localparam logic [OVS_W-1:0] SMP_A    = OVS_W'(7);
  localparam logic [OVS_W-1:0] SMP_B    = OVS_W'(8);
  localparam logic [OVS_W-1:0] SMP_C    = OVS_W'(9);
  localparam logic [OVS_W-1:0] LAST_SUB = OVS_W'(OVS - 1);

  localparam logic [BIT_W-1:0] TX_LAST9 = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] TX_LAST8 = BIT_W'(FRAME_W - 2);
  localparam logic [BIT_W-1:0] RX_LAST9 = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] RX_LAST8 = BIT_W'(WORD_W - 2);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_mp_baud.sv
module uart_mp_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? div : cnt - 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick); // R1
endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
  import uart_mp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine_bit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              txd,
  output logic              done
);
  logic [FRAME_W-1:0] sh;
  logic [OVS_W-1:0]   sub;
  logic [BIT_W-1:0]   bitn;
  logic               busy;
  logic [WORD_W-1:0]  hold;
  logic               hold_full;
  logic               last_bit;
  logic               accept;
  logic               load;
  logic [FRAME_W-1:0] frame;

  assign last_bit = (bitn == (nine_bit ? TX_LAST9 : TX_LAST8));
  assign in_ready = !hold_full;
  assign accept   = in_valid && !hold_full;
  // the waiting word enters the shifter only on a tick, either from idle
  // or at the tick that closes the stop bit of the current frame
  assign load     = tick && hold_full && (!busy || (sub == LAST_SUB && last_bit));
  assign frame    = nine_bit ? {1'b1, hold, 1'b0}
                             : {2'b11, hold[WORD_W-2:0], 1'b0};
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '1;
      sub       <= '0;
      bitn      <= '0;
      busy      <= 1'b0;
      hold      <= '0;
      hold_full <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (load) begin
        sh        <= frame;
        busy      <= 1'b1;
        sub       <= '0;
        bitn      <= '0;
        hold_full <= 1'b0;
      end else if (tick && busy) begin
        sub <= sub + 1'b1;
        if (sub == LAST_SUB) begin
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            bitn <= bitn + 1'b1;
          end
        end
      end
      if (accept) begin
        hold      <= in_data;
        hold_full <= 1'b1;
        done      <= 1'b0;
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_TX_HELD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !tick) |=> !in_ready); // R3
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              nine_bit,
  input  logic              mp_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              frame_err,
  output logic              overrun
);
  logic [SYNC_STAGES-1:0] sync;
  logic                   rx_s;
  rx_state_e              state;
  logic [OVS_W-1:0]       cnt;
  logic [BIT_W-1:0]       bitn;
  logic [1:0]             votes;
  logic [WORD_W-1:0]      sh;
  logic                   maj;
  logic                   commit;
  logic                   flag;
  logic                   keep;
  logic                   pop;
  logic [WORD_W-1:0]      new_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_STAGES-2:0], rxd};
  end
  assign rx_s = sync[SYNC_STAGES-1];

  assign maj      = (votes[0] & votes[1]) | (votes[0] & rx_s) | (votes[1] & rx_s);
  assign commit   = tick && (state == RX_STOP) && (cnt == SMP_C);
  assign flag     = nine_bit ? sh[WORD_W-1] : maj;
  assign keep     = commit && (!mp_mode || flag);
  assign pop      = out_valid && out_ready;
  assign new_word = {nine_bit & sh[WORD_W-1], sh[WORD_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      votes <= 2'b11;
      sh    <= '0;
    end else if (tick) begin
      if (state == RX_IDLE) begin
        if (!rx_s) begin
          state <= RX_START;
          cnt   <= OVS_W'(1);
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == SMP_A || cnt == SMP_B) votes <= {votes[0], rx_s};
        unique case (state)
          RX_START: begin
            if (cnt == SMP_C && maj)      state <= RX_IDLE;
            else if (cnt == LAST_SUB) begin
              state <= RX_DATA;
              bitn  <= '0;
            end
          end
          RX_DATA: begin
            if (cnt == SMP_C) sh[bitn] <= maj;
            if (cnt == LAST_SUB) begin
              if (bitn == (nine_bit ? RX_LAST9 : RX_LAST8)) state <= RX_STOP;
              else                                          bitn  <= bitn + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == SMP_C) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else if (keep) begin
      if (!out_valid || pop) begin
        out_valid <= 1'b1;
        out_data  <= new_word;
        frame_err <= !maj;
        overrun   <= 1'b0;
      end else begin
        overrun   <= 1'b1;
      end
    end else if (pop) begin
      out_valid <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end
  end

  AST_OVR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> out_valid); // R9
  AST_FE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> out_valid); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_MP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mp_mode && !flag && !out_valid) |=> !out_valid); // R10
endmodule

// File: rtl/uart_mp.sv
module uart_mp
  import uart_mp_pkg::*;
#(
  parameter int DIV_HI_W    = 4,
  parameter int DIV_LO_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_HI_W-1:0] div_hi,
  input  logic [DIV_LO_W-1:0] div_lo,
  input  logic                nine_bit,
  input  logic                mp_mode,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [WORD_W-1:0]   tx_data,
  output logic                txd,
  output logic                tx_done,
  input  logic                rxd,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [WORD_W-1:0]   rx_data,
  output logic                rx_frame_err,
  output logic                rx_overrun
);
  localparam int DIV_W = DIV_HI_W + DIV_LO_W;

  logic [DIV_W-1:0] div;
  logic             tick;

  assign div = {div_hi, div_lo};

  uart_mp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (div),
    .tick  (tick)
  );

  uart_mp_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .nine_bit (nine_bit),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .txd      (txd),
    .done     (tx_done)
  );

  uart_mp_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rxd       (rxd),
    .nine_bit  (nine_bit),
    .mp_mode   (mp_mode),
    .out_valid (rx_valid),
    .out_ready (rx_ready),
    .out_data  (rx_data),
    .frame_err (rx_frame_err),
    .overrun   (rx_overrun)
  );
endmodule

// File: tb/sim_uart_mp.sv
module sim_uart_mp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_hi = '0;
  logic [7:0] div_lo = '0;
  logic       nine_bit = 1'b0;
  logic       mp_mode = 1'b0;
  logic       tx_valid = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_ready;
  logic       txd;
  logic       tx_done;
  logic       rx_line;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [8:0] rx_data;
  logic       rx_frame_err;
  logic       rx_overrun;
  logic       loop = 1'b1;
  logic       drv = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign rx_line = loop ? txd : drv;

  uart_mp u0 (
    .clk(clk), .rst_n(rst_n), .div_hi(div_hi), .div_lo(div_lo),
    .nine_bit(nine_bit), .mp_mode(mp_mode),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .txd(txd), .tx_done(tx_done), .rxd(rx_line),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = v;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(output bit got);
    got = 1'b0;
    for (int i = 0; i < 60000 && !got; i++) begin
      @(negedge clk);
      if (rx_valid) got = 1'b1;
    end
  endtask

  task automatic pop();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_tx_done();
    for (int i = 0; i < 60000 && !tx_done; i++) @(negedge clk);
  endtask

  // bit k of the frame is driven for 16 clocks (divisor 0); g picks a bit
  // whose 9th sample is inverted
  task automatic drive_frame(input logic [10:0] bits, input int n, input int g);
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        drv = bits[k] ^ ((k == g) && (c == 8));
      end
    end
    @(negedge clk);
    drv = 1'b1;
  endtask

  initial begin
    bit got;
    int w;
    logic [8:0] v;
    logic [9:0] fr;

    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11 txd", txd, 1);
    chk(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);
    chk(tx_done == 1'b0, "R11 tx_done", tx_done, 0);
    chk(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    chk(rx_frame_err == 1'b0 && rx_overrun == 1'b0, "R11 flags",
        {rx_frame_err, rx_overrun}, 0);

    // R2 R7: every 8-bit value through the loop
    for (int i = 0; i < 256; i++) begin
      send(9'(i));
      wait_rx(got);
      chk(got && rx_data == {1'b0, 8'(i)}, "R2 R7 loop8", rx_data, i);
      chk(!rx_frame_err && !rx_overrun, "R8 R9 clean", {rx_frame_err, rx_overrun}, 0);
      pop();
    end

    // R1: start bit width for several divisors
    div_lo = 8'd5;
    send(9'h001);
    while (txd) @(negedge clk);
    w = 0;
    while (!txd) begin w++; @(negedge clk); end
    chk(w == 16 * 6, "R1 width div5", w, 16 * 6);
    wait_rx(got); pop();
    div_hi = 4'd1; div_lo = 8'd0;
    send(9'h001);
    while (txd) @(negedge clk);
    w = 0;
    while (!txd) begin w++; @(negedge clk); end
    chk(w == 16 * 257, "R1 width div256", w, 16 * 257);
    wait_rx(got);
    chk(got && rx_data == 9'h001, "R1 data div256", rx_data, 1);
    pop();

    // R2: bit positions on txd at divisor 2
    div_hi = 4'd0; div_lo = 8'd2;
    fr = {1'b1, 8'hA5, 1'b0};
    send(9'h0A5);
    while (txd) @(negedge clk);
    idle(24);
    for (int k = 0; k < 10; k++) begin
      chk(txd == fr[k], "R2 bit on txd", txd, fr[k]);
      if (k < 9) idle(48);
    end
    wait_rx(got); pop();
    wait_tx_done();

    // R3 R4: holding register and completion flag
    div_lo = 8'd0;
    send(9'h011);
    send(9'h022);
    idle(20);
    chk(!tx_ready, "R3 held word blocks", tx_ready, 0);
    chk(!tx_done, "R4 busy not done", tx_done, 0);
    wait_rx(got);
    chk(got && rx_data == 9'h011, "R3 first word", rx_data, 9'h011);
    pop();
    wait_rx(got);
    chk(got && rx_data == 9'h022, "R3 second word", rx_data, 9'h022);
    pop();
    wait_tx_done();
    chk(tx_done && tx_ready, "R4 done set", {tx_done, tx_ready}, 3);
    send(9'h033);
    chk(!tx_done, "R4 done cleared", tx_done, 0);
    wait_rx(got); pop();
    wait_tx_done();

    // R7: 9-bit characters
    nine_bit = 1'b1;
    for (int i = 0; i < 32; i++) begin
      v = {i[0], 8'(i * 29 + 7)};
      send(v);
      wait_rx(got);
      chk(got && rx_data == v, "R7 loop9", rx_data, v);
      pop();
    end

    // R10: address filter in 9-bit mode
    mp_mode = 1'b1;
    send(9'h0AA);
    wait_tx_done();
    idle(30);
    chk(!rx_valid && !rx_overrun, "R10 data dropped", rx_valid, 0);
    send(9'h155);
    wait_rx(got);
    chk(got && rx_data == 9'h155, "R10 address kept", rx_data, 9'h155);
    pop();
    mp_mode = 1'b0;
    send(9'h033);
    wait_rx(got);
    chk(got && rx_data == 9'h033, "R10 filter off", rx_data, 9'h033);
    pop();
    wait_tx_done();

    // R10: 8-bit mode, flag in stop position
    nine_bit = 1'b0;
    loop = 1'b0;
    mp_mode = 1'b1;
    idle(5);
    drive_frame({1'b0, 1'b0, 8'h5A, 1'b0}, 10, -1);
    idle(40);
    chk(!rx_valid && !rx_frame_err, "R10 8-bit drop", {rx_valid, rx_frame_err}, 0);
    mp_mode = 1'b0;

    // R8: framing error
    drive_frame({1'b1, 1'b0, 8'h3C, 1'b0}, 10, -1);
    wait_rx(got);
    chk(got && rx_frame_err && rx_data == 9'h03C, "R8 zero stop",
        {rx_frame_err, rx_data}, {1'b1, 9'h03C});
    pop();
    chk(!rx_frame_err, "R8 cleared on pop", rx_frame_err, 0);
    drive_frame({1'b1, 1'b1, 8'hC3, 1'b0}, 10, -1);
    wait_rx(got);
    chk(got && !rx_frame_err && rx_data == 9'h0C3, "R8 good stop",
        {rx_frame_err, rx_data}, 9'h0C3);
    pop();

    // R5: short low pulse is rejected
    idle(5);
    @(negedge clk); drv = 1'b0;
    idle(3);
    drv = 1'b1;
    idle(40);
    chk(!rx_valid, "R5 short pulse", rx_valid, 0);
    drive_frame({1'b1, 1'b1, 8'h96, 1'b0}, 10, -1);
    wait_rx(got);
    chk(got && rx_data == 9'h096, "R5 recovery", rx_data, 9'h096);
    pop();

    // R6: single glitched sample in a data bit and in the start bit
    drive_frame({1'b1, 1'b1, 8'h69, 1'b0}, 10, 3);
    wait_rx(got);
    chk(got && rx_data == 9'h069, "R6 data glitch", rx_data, 9'h069);
    pop();
    drive_frame({1'b1, 1'b1, 8'h69, 1'b0}, 10, 0);
    wait_rx(got);
    chk(got && rx_data == 9'h069, "R6 start glitch", rx_data, 9'h069);
    pop();

    // R9: overrun keeps the older character
    loop = 1'b1;
    idle(5);
    send(9'h041);
    send(9'h042);
    wait_tx_done();
    idle(20);
    chk(rx_valid && rx_data == 9'h041, "R9 older kept", rx_data, 9'h041);
    chk(rx_overrun, "R9 overrun set", rx_overrun, 1);
    pop();
    chk(!rx_valid && !rx_overrun, "R9 cleared", {rx_valid, rx_overrun}, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule